// File: doc/BRIEF.md
# Instruction Issue Cycle Sequencer

This block sits between an instruction fetch stage and the execute stage. In every cycle it decides whether execute runs a real instruction, runs an inserted no-operation slot, or waits. A fetch stage offers one 24-bit instruction word per cycle. A decoder supplies four flags that describe that word: it is the first half of a two-word instruction, it changes the program counter, it performs a slow read (program-space, table or special-register), or it is a conditional skip whose condition holds.

The sequencer turns these flags into a cycle cost. It tells the fetch stage when a word has been taken and holds the fetch stage back while NOP slots fill the pipeline. The second half of a two-word instruction is marked by a zero top byte. If such a word turns up where an instruction should start, it is run as a NOP. A taken skip throws away the following instruction. The cost of the skip therefore depends on whether that instruction is one word long or two.

Top module: `issue_seq_top`

## Requirements
- R1: When a word with a non-zero top byte (bits 23:16) is offered at an instruction start, `execValid` and `consume` are high in that cycle and `nopSlot` and `busy` are low. A single-word instruction with no cost flags takes exactly one cycle.
- R2: A two-word instruction (`isTwoWord` high on its first word) takes a second cycle. In that cycle `nopSlot`, `consume` and `busy` are high and `execValid` is low. The decoder flags offered with the second word have no effect.
- R3: A word whose top byte is zero, offered at an instruction start, is taken as a NOP slot in one cycle (`nopSlot`=1, `consume`=1, `execValid`=0, `busy`=0). Its decoder flags have no effect.
- R4: `changesPc` and `slowRead` each add one NOP slot, and the two costs add up. These slots come after any second-word cycle. They have `nopSlot`=1, `busy`=1 and `consume`=0.
- R5: A taken skip (`skipTaken`) drops the instruction that follows it. The first word of the dropped instruction is taken as one NOP slot. If the decoder marks that word as two-word, its second word is taken as one more NOP slot. The whole skip therefore costs 2 or 3 cycles, plus any cost slots of its own. During these slots `busy` is high, and the flags of the dropped words other than `isTwoWord` on the first word have no effect.
- R6: In any cycle that needs a word while `wordValid` is low, `execValid`, `nopSlot` and `consume` stay low and the sequence does not advance. `busy` stays high if an instruction is still in progress. `consume` is never high without `wordValid`.
- R7: A synchronous reset (`rst` high) clears all pending slots and pending skips. The first word offered after reset is treated as an instruction start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | The fetch stage offers a word this cycle |
| fetchWord | input | 24 | Offered instruction word |
| isTwoWord | input | 1 | Decoder: the word starts a two-word instruction |
| changesPc | input | 1 | Decoder: the instruction changes the program counter |
| slowRead | input | 1 | Decoder: program-space, table or special-register read |
| skipTaken | input | 1 | Decoder: a skip whose condition holds |
| execValid | output | 1 | Execute runs a real instruction this cycle |
| nopSlot | output | 1 | Execute runs an inserted NOP slot this cycle |
| consume | output | 1 | The offered word is taken; the fetch stage advances |
| busy | output | 1 | An instruction is still in progress |

## Verification
The hardest case to reach is a fetch gap in a word-consuming slot. One example is a gap while a dropped two-word instruction is being discarded after a skip that also carries cost slots. Another is a gap on the second word of a two-word instruction. The stimulus builds long random instruction streams. In these streams, costs, skips, dropped two-word instructions and stray zero-top-byte words are mixed together, and the fetch stage drops its valid signal on a fixed beat pattern. Over many cycles, gaps land in every kind of slot. A separate directed step drives reset in the middle of a cost slot.

// File: rtl/issue_seq_pkg.sv
package issue_seq_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_SECOND,
    ST_FILL,
    ST_SKIP1,
    ST_SKIP2
  } seqState_t;

  // strobes from control to the cost datapath
  typedef struct packed {
    logic loadCost;
    logic decFill;
    logic clrSkip;
  } dpStrobe_t;

endpackage

// File: rtl/issue_seq_dp.sv
module issue_seq_dp
  import issue_seq_pkg::*;
#(
  parameter int MARK_W    = 8,
  parameter int PC_COST   = 1,
  parameter int READ_COST = 1,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MARK_W-1:0] markBits,
  input  logic             changesPc,
  input  logic             slowRead,
  input  logic             skipTaken,
  input  dpStrobe_t        strobe,
  output logic             markZero,
  output logic             costNonZero,
  output logic             pendZero,
  output logic             fillLast,
  output logic             skipPend
);

  logic [CNT_W-1:0] pendCnt;
  logic [CNT_W-1:0] costNow;

  always_comb begin
    costNow = '0;
    if (changesPc) costNow = costNow + CNT_W'(PC_COST);
    if (slowRead)  costNow = costNow + CNT_W'(READ_COST);
  end

  assign markZero    = (markBits == '0);
  assign costNonZero = (costNow != '0);
  assign pendZero    = (pendCnt == '0);
  assign fillLast    = (pendCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pendCnt  <= '0;
      skipPend <= 1'b0;
    end else if (strobe.loadCost) begin
      pendCnt  <= costNow;
      skipPend <= skipTaken;
    end else begin
      if (strobe.decFill) pendCnt  <= pendCnt - CNT_W'(1);
      if (strobe.clrSkip) skipPend <= 1'b0;
    end
  end

endmodule

// File: rtl/issue_seq_ctrl.sv
module issue_seq_ctrl
  import issue_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wordValid,
  input  logic      isTwoWord,
  input  logic      skipTaken,
  input  logic      markZero,
  input  logic      costNonZero,
  input  logic      pendZero,
  input  logic      fillLast,
  input  logic      skipPend,
  output dpStrobe_t strobe,
  output logic      execValid,
  output logic      nopSlot,
  output logic      consume,
  output logic      busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_START;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    execValid = 1'b0;
    nopSlot   = 1'b0;
    consume   = 1'b0;
    busy      = (state != ST_START);
    case (state)
      ST_START: if (wordValid) begin
        consume = 1'b1;
        if (markZero) begin
          nopSlot = 1'b1;
        end else begin
          execValid       = 1'b1;
          strobe.loadCost = 1'b1;
          if (isTwoWord)        nextState = ST_SECOND;
          else if (costNonZero) nextState = ST_FILL;
          else if (skipTaken)   nextState = ST_SKIP1;
        end
      end
      ST_SECOND: if (wordValid) begin
        consume = 1'b1;
        nopSlot = 1'b1;
        if (!pendZero)    nextState = ST_FILL;
        else if (skipPend) nextState = ST_SKIP1;
        else               nextState = ST_START;
      end
      ST_FILL: begin
        nopSlot        = 1'b1;
        strobe.decFill = 1'b1;
        if (fillLast) nextState = skipPend ? ST_SKIP1 : ST_START;
      end
      ST_SKIP1: if (wordValid) begin
        consume        = 1'b1;
        nopSlot        = 1'b1;
        strobe.clrSkip = 1'b1;
        nextState      = isTwoWord ? ST_SKIP2 : ST_START;
      end
      ST_SKIP2: if (wordValid) begin
        consume   = 1'b1;
        nopSlot   = 1'b1;
        nextState = ST_START;
      end
      default: nextState = ST_START;
    endcase
  end

endmodule

// File: rtl/issue_seq_top.sv
module issue_seq_top
  import issue_seq_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int MARK_W    = 8,
  parameter int PC_COST   = 1,
  parameter int READ_COST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              isTwoWord,
  input  logic              changesPc,
  input  logic              slowRead,
  input  logic              skipTaken,
  output logic              execValid,
  output logic              nopSlot,
  output logic              consume,
  output logic              busy
);

  localparam int CNT_W = $clog2(PC_COST + READ_COST + 1);

  dpStrobe_t strobe;
  logic markZero, costNonZero, pendZero, fillLast, skipPend;

  issue_seq_dp #(
    .MARK_W(MARK_W), .PC_COST(PC_COST), .READ_COST(READ_COST), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst(rst),
    .markBits(fetchWord[WORD_W-1 -: MARK_W]),
    .changesPc(changesPc), .slowRead(slowRead), .skipTaken(skipTaken),
    .strobe(strobe),
    .markZero(markZero), .costNonZero(costNonZero), .pendZero(pendZero),
    .fillLast(fillLast), .skipPend(skipPend)
  );

  issue_seq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .wordValid(wordValid),
    .isTwoWord(isTwoWord), .skipTaken(skipTaken),
    .markZero(markZero), .costNonZero(costNonZero), .pendZero(pendZero),
    .fillLast(fillLast), .skipPend(skipPend),
    .strobe(strobe),
    .execValid(execValid), .nopSlot(nopSlot), .consume(consume), .busy(busy)
  );

endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk #(
  parameter int WORD_W = 24,
  parameter int MARK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wordValid,
  input logic [WORD_W-1:0] fetchWord,
  input logic              isTwoWord,
  input logic              changesPc,
  input logic              slowRead,
  input logic              skipTaken,
  input logic              execValid,
  input logic              nopSlot,
  input logic              consume,
  input logic              busy
);

  // R1
  exec_nop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(execValid && nopSlot));

  // R3
  exec_mark_chk: assert property (@(posedge clk) disable iff (rst)
    execValid |-> (fetchWord[WORD_W-1 -: MARK_W] != '0));

  // R2
  two_word_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (execValid && isTwoWord) |=> busy);

  // R4
  fill_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (nopSlot && !consume) |-> busy);

  // R5
  skip_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (execValid && skipTaken && !isTwoWord && !changesPc && !slowRead) |=> busy);

  // R6
  consume_valid_chk: assert property (@(posedge clk) disable iff (rst)
    consume |-> wordValid);

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy);

endmodule

bind issue_seq_top issue_seq_chk #(.WORD_W(WORD_W), .MARK_W(MARK_W)) chk_i (.*);

// File: tb/issue_seq_top_tb_top.sv
module issue_seq_top_tb_top;

  localparam int N = 600;

  typedef struct {
    logic  e, n, c, b, w;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wordValid = 1'b0;
  logic [23:0] fetchWord = '0;
  logic isTwoWord = 1'b0, changesPc = 1'b0, slowRead = 1'b0, skipTaken = 1'b0;
  logic execValid, nopSlot, consume, busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [23:0] sWord [N];
  logic        sTw [N], sPc [N], sRd [N], sSk [N];
  int          nWords = 0;
  exp_t        q[$];

  always #2 clk = ~clk;

  issue_seq_top dut_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .fetchWord(fetchWord),
    .isTwoWord(isTwoWord), .changesPc(changesPc), .slowRead(slowRead),
    .skipTaken(skipTaken), .execValid(execValid), .nopSlot(nopSlot),
    .consume(consume), .busy(busy)
  );

  task automatic addWord(input logic [23:0] w, input logic tw, input logic pc,
                         input logic rd, input logic sk);
    sWord[nWords] = w; sTw[nWords] = tw; sPc[nWords] = pc;
    sRd[nWords] = rd; sSk[nWords] = sk;
    nWords++;
  endtask

  task automatic pushExp(input logic e, input logic n, input logic c,
                         input logic b, input logic w, input string tag);
    exp_t it;
    it.e = e; it.n = n; it.c = c; it.b = b; it.w = w; it.tag = tag;
    q.push_back(it);
  endtask

  // driver: builds the word stream and the expected slot sequence
  task automatic buildStream();
    while (nWords < N - 6) begin
      logic [31:0] r, r2;
      r = $urandom;
      if (r[2:0] == 3'd0) begin
        addWord({8'h00, r[23:8]}, r[24], r[25], r[26], r[27]);
        pushExp(0, 1, 1, 0, 1, "R3");
      end else begin
        logic tw, pc, rd, sk;
        tw = r[3]; pc = r[4]; rd = r[5] & r[6]; sk = r[7] & r[8];
        addWord({r[15:8] | 8'h01, r[31:16]}, tw, pc, rd, sk);
        pushExp(1, 0, 1, 0, 1, "R1");
        if (tw) begin
          addWord({8'h00, r[27:12]}, r[9], r[10], r[11], r[12]);
          pushExp(0, 1, 1, 1, 1, "R2");
        end
        for (int k = 0; k < int'(pc) + int'(rd); k++) pushExp(0, 1, 0, 1, 0, "R4");
        if (sk) begin
          r2 = $urandom;
          addWord({r2[15:8] | 8'h80, r2[31:16]}, r2[0], r2[1], r2[2], r2[3]);
          pushExp(0, 1, 1, 1, 1, "R5");
          if (r2[0]) begin
            addWord({8'h00, r2[23:8]}, r2[4], r2[5], r2[6], r2[7]);
            pushExp(0, 1, 1, 1, 1, "R5");
          end
        end
      end
    end
  endtask

  task automatic check4(input string tag, input logic e, input logic n,
                        input logic c, input logic b);
    total++;
    if ({execValid, nopSlot, consume, busy} !== {e, n, c, b}) begin
      bad++;
      $display("FAIL %s exec/nop/cons/busy got %b%b%b%b exp %b%b%b%b",
               tag, execValid, nopSlot, consume, busy, e, n, c, b);
    end
  endtask

  task automatic driveWord(input logic v, input logic [23:0] w, input logic tw,
                           input logic pc, input logic rd, input logic sk);
    wordValid = v; fetchWord = w; isTwoWord = tw;
    changesPc = pc; slowRead = rd; skipTaken = sk;
  endtask

  // monitor: pops expected slots and compares them with the outputs
  initial begin
    int ptr = 0;
    int cyc = 0;
    buildStream();
    repeat (3) @(negedge clk);
    #1 check4("R7 reset state", 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    while (q.size() != 0) begin
      exp_t it;
      logic gap;
      @(negedge clk);
      cyc++;
      gap = (cyc % 5 == 2) || (ptr >= nWords);
      if (ptr < nWords) driveWord(!gap, sWord[ptr], sTw[ptr], sPc[ptr], sRd[ptr], sSk[ptr]);
      else              driveWord(1'b0, '0, 0, 0, 0, 0);
      #1;
      it = q[0];
      if (it.w && gap) begin
        check4({"R6 gap during ", it.tag}, 0, 0, 0, it.b);
      end else begin
        void'(q.pop_front());
        check4(it.tag, it.e, it.n, it.c, it.b);
        if (it.c) ptr++;
      end
    end
    total++;
    if (ptr != nWords) begin
      bad++;
      $display("FAIL R1 words taken got %0d exp %0d", ptr, nWords);
    end
    // R7: reset in the middle of cost slots
    @(negedge clk);
    driveWord(1'b1, 24'hAB1234, 0, 1, 1, 0);
    #1 check4("R7 issue before reset", 1, 0, 1, 0);
    @(negedge clk);
    driveWord(1'b0, '0, 0, 0, 0, 0);
    #1 check4("R4 fill before reset", 0, 1, 0, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    driveWord(1'b1, 24'hCD0001, 0, 0, 0, 0);
    #1 check4("R7 start after reset", 1, 0, 1, 0);
    @(negedge clk);
    driveWord(1'b0, '0, 0, 0, 0, 0);
    #1 check4("R7 idle after reset", 0, 0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule